// File: doc/BRIEF.md
# Descriptor Poll-Demand Channel Controller

This block is the control state machine for one DMA channel of a network controller. A parameter sets whether the channel moves transmit or receive traffic. The channel holds a word-aligned descriptor list base and a current descriptor pointer. It fetches one descriptor at a time over a request/acknowledge interface, and the acknowledge carries an ownership flag. If the descriptor belongs to the DMA, the channel enters its running state. If not, it parks in a suspended state and raises a sticky buffer-unavailable bit in its interrupt status word.

Software restarts a suspended channel by writing any value to a start-demand register, which the block sees as a write strobe. A start control leaves the stopped state, and a stop control returns the channel to it. The block does not move data, handle frames or master the bus. It only sequences the channel and produces the addresses of the descriptors to fetch.

Top module: `dma_poll_ctrl`

## Requirements
- R1: After reset the state is stopped (state_o = 0), the base and current pointers are zero, the status word is zero and no fetch is requested.
- R2: A base write while stopped stores the data with bits 1:0 forced to zero. A base write in any other state leaves base_addr_o unchanged.
- R3: start_i while stopped copies the base into the current pointer and moves to fetching (state_o = 1) on the next cycle. fetch_req_o is then high and fetch_addr_o equals the base. start_i in any other state is ignored.
- R4: fetch_req_o is high exactly in the fetching state. It stays high, with fetch_addr_o held stable, until a cycle in which fetch_ack_i is high, so only one fetch is outstanding.
- R5: A fetch acknowledge with fetch_own_i = 1 moves the channel to running (state_o = 3).
- R6: A fetch acknowledge with fetch_own_i = 0 moves the channel to suspended (state_o = 2) and sets the buffer-unavailable bit: bit 2 of int_status_o for a transmit channel, bit 7 for a receive channel.
- R7: demand_wr_i while suspended starts a new fetch at the unchanged current pointer. In the stopped, fetching or running state it has no effect.
- R8: desc_done_i while running, with no stop requested, advances the current pointer by STRIDE bytes and starts the next fetch on the following cycle.
- R9: stop_i while suspended returns the channel to stopped on the next cycle. stop_i while fetching or running is remembered. The channel then stops at the next desc_done_i, or at an acknowledge that reports the descriptor not owned.
- R10: The buffer-unavailable bit stays set until a status write whose data has that bit set. A status write without that bit has no effect. If a clear and a new set fall in the same cycle, the bit ends up set.
- R11: frame_wait_o is high only in a receive channel that is running. It is always low in a transmit channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Leave the stopped state (pulse) |
| stop_i | input | 1 | Request return to the stopped state (pulse) |
| demand_wr_i | input | 1 | Host write strobe to the start-demand register |
| base_wr_i | input | 1 | Host write strobe to the list base register |
| base_wdata_i | input | AW | List base write data |
| sts_wr_i | input | 1 | Host write strobe to the status register (write one to clear) |
| sts_wdata_i | input | SW | Status write data |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_addr_o | output | AW | Address of the descriptor being fetched |
| fetch_ack_i | input | 1 | Fetch response handshake |
| fetch_own_i | input | 1 | Descriptor owned by the DMA; valid with fetch_ack_i |
| desc_done_i | input | 1 | Current descriptor finished (pulse) |
| state_o | output | 2 | 0 stopped, 1 fetching, 2 suspended, 3 running |
| base_addr_o | output | AW | List base register |
| cur_addr_o | output | AW | Current descriptor pointer |
| int_status_o | output | SW | Interrupt status word holding the buffer-unavailable bit |
| frame_wait_o | output | 1 | Receive channel running and waiting for a frame |

## Verification
Two events can meet in the same cycle. One is the host's write-one-to-clear of the buffer-unavailable bit. The other is a fetch acknowledge reporting a descriptor not owned, which sets that same bit. A directed step drives both together and expects the bit to remain set. A later long pseudo-random run makes the two meet many times, and a behavioural model compares the status word on every cycle. The same run also lets stop, start-demand and descriptor-done pulses arrive together, and the model decides which one takes effect.

// File: rtl/dma_poll_pkg.sv
package dma_poll_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SUSP  = 2'd2,
    ST_RUN   = 2'd3
  } chan_state_e;
endpackage

// File: rtl/dma_poll_fsm.sv
module dma_poll_fsm
  import dma_poll_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        demand_wr_i,
  input  logic        fetch_ack_i,
  input  logic        fetch_own_i,
  input  logic        desc_done_i,
  output chan_state_e state_o,
  output logic        load_cur_o,
  output logic        adv_cur_o,
  output logic        set_bu_o,
  output logic        cfg_ok_o
);
  chan_state_e st_q, st_d;
  logic        pend_q, pend_d;

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    load_cur_o = 1'b0;
    adv_cur_o  = 1'b0;
    set_bu_o   = 1'b0;
    unique case (st_q)
      ST_STOP: begin
        pend_d = 1'b0;
        if (start_i) begin
          st_d       = ST_FETCH;
          load_cur_o = 1'b1;
        end
      end
      ST_FETCH: begin
        if (stop_i) pend_d = 1'b1;
        if (fetch_ack_i) begin
          if (fetch_own_i) begin
            st_d = ST_RUN;
          end else begin
            set_bu_o = 1'b1;
            if (pend_q || stop_i) begin
              st_d   = ST_STOP;
              pend_d = 1'b0;
            end else begin
              st_d = ST_SUSP;
            end
          end
        end
      end
      ST_SUSP: begin
        if (stop_i) begin
          st_d   = ST_STOP;
          pend_d = 1'b0;
        end else if (demand_wr_i) begin
          st_d = ST_FETCH;
        end
      end
      ST_RUN: begin
        if (stop_i) pend_d = 1'b1;
        if (desc_done_i) begin
          if (pend_q || stop_i) begin
            st_d   = ST_STOP;
            pend_d = 1'b0;
          end else begin
            adv_cur_o = 1'b1;
            st_d      = ST_FETCH;
          end
        end
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_STOP;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign state_o  = st_q;
  assign cfg_ok_o = (st_q == ST_STOP);

  assert_own_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH && fetch_ack_i && fetch_own_i) |=> (st_q == ST_RUN));

  assert_empty_susp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH && fetch_ack_i && !fetch_own_i && !pend_q && !stop_i)
      |=> (st_q == ST_SUSP));

  assert_run_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !desc_done_i) |=> (st_q == ST_RUN));

  assert_stop_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOP && !start_i) |=> (st_q == ST_STOP));

  assert_susp_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP && stop_i) |=> (st_q == ST_STOP));
endmodule

// File: rtl/dma_poll_ptr.sv
module dma_poll_ptr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned STRIDE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_wr_i,
  input  logic          cfg_ok_i,
  input  logic [AW-1:0] base_wdata_i,
  input  logic          load_i,
  input  logic          adv_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] cur_o
);
  localparam logic [AW-1:0] ALIGN_MASK = {{(AW-2){1'b1}}, 2'b00};
  localparam logic [AW-1:0] STEP       = AW'(STRIDE);

  logic [AW-1:0] base_q, cur_q;
  logic          base_we;

  assign base_we = base_wr_i && cfg_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_we) base_q <= base_wdata_i & ALIGN_MASK;
      if (load_i)     cur_q <= base_q;
      else if (adv_i) cur_q <= cur_q + STEP;
    end
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;

  assert_base_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q[1:0] == 2'b00);

  assert_base_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok_i |=> $stable(base_q));

  assert_cur_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (cur_q - $past(cur_q) == STEP));
endmodule

// File: rtl/dma_poll_sts.sv
module dma_poll_sts #(
  parameter int unsigned SW     = 32,
  parameter int unsigned BU_BIT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          wr_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] status_o
);
  localparam logic [SW-1:0] BU_MASK = SW'(1) << BU_BIT;

  logic bu_q, clr_hit;

  assign clr_hit = wr_i && |(wdata_i & BU_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bu_q <= 1'b0;
    else if (set_i)   bu_q <= 1'b1;  // new event beats a same-cycle clear
    else if (clr_hit) bu_q <= 1'b0;
  end

  assign status_o = bu_q ? BU_MASK : '0;

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != '0 && !clr_hit) |=> (status_o == BU_MASK));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (status_o == BU_MASK));

  assert_one_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) <= 1);
endmodule

// File: rtl/dma_poll_ctrl.sv
module dma_poll_ctrl
  import dma_poll_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SW     = 32,
  parameter int unsigned STRIDE = 16,
  parameter bit          IS_RX  = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          demand_wr_i,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_wdata_i,
  input  logic          sts_wr_i,
  input  logic [SW-1:0] sts_wdata_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ack_i,
  input  logic          fetch_own_i,
  input  logic          desc_done_i,
  output logic [1:0]    state_o,
  output logic [AW-1:0] base_addr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [SW-1:0] int_status_o,
  output logic          frame_wait_o
);
  localparam int unsigned BU_BIT = IS_RX ? 7 : 2;

  chan_state_e st;
  logic        load_cur, adv_cur, set_bu, cfg_ok;
  logic [AW-1:0] cur;

  dma_poll_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .demand_wr_i (demand_wr_i),
    .fetch_ack_i (fetch_ack_i),
    .fetch_own_i (fetch_own_i),
    .desc_done_i (desc_done_i),
    .state_o     (st),
    .load_cur_o  (load_cur),
    .adv_cur_o   (adv_cur),
    .set_bu_o    (set_bu),
    .cfg_ok_o    (cfg_ok)
  );

  dma_poll_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_wr_i    (base_wr_i),
    .cfg_ok_i     (cfg_ok),
    .base_wdata_i (base_wdata_i),
    .load_i       (load_cur),
    .adv_i        (adv_cur),
    .base_o       (base_addr_o),
    .cur_o        (cur)
  );

  dma_poll_sts #(.SW(SW), .BU_BIT(BU_BIT)) u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_bu),
    .wr_i     (sts_wr_i),
    .wdata_i  (sts_wdata_i),
    .status_o (int_status_o)
  );

  assign state_o      = st;
  assign cur_addr_o   = cur;
  assign fetch_req_o  = (st == ST_FETCH);
  assign fetch_addr_o = cur;

  generate
    if (IS_RX) begin : g_rx
      assign frame_wait_o = (st == ST_RUN);
    end else begin : g_tx
      assign frame_wait_o = 1'b0;
    end
  endgenerate

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_ack_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

  assert_wait_mode_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wait_o |-> (IS_RX && state_o == 2'd3));
endmodule

// File: tb/dma_poll_ctrl_bench.sv
module dma_poll_ctrl_bench;
  localparam int AW = 32;
  localparam int SW = 32;
  localparam int STRIDE = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, demand_wr_i = 0, base_wr_i = 0, sts_wr_i = 0;
  logic fetch_ack_i = 0, fetch_own_i = 0, desc_done_i = 0;
  logic [AW-1:0] base_wdata_i = '0;
  logic [SW-1:0] sts_wdata_i = '0;

  logic          tx_req, rx_req, tx_wait, rx_wait;
  logic [AW-1:0] tx_faddr, rx_faddr, tx_base, rx_base, tx_cur, rx_cur;
  logic [1:0]    tx_st, rx_st;
  logic [SW-1:0] tx_sts, rx_sts;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural reference
  int          m_st;
  logic [31:0] m_base, m_cur;
  bit          m_bu_tx, m_bu_rx, m_pend;

  always #2.5 clk = ~clk;

  dma_poll_ctrl #(.IS_RX(1'b0)) u_dma_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .demand_wr_i(demand_wr_i), .base_wr_i(base_wr_i), .base_wdata_i(base_wdata_i),
    .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i), .fetch_req_o(tx_req),
    .fetch_addr_o(tx_faddr), .fetch_ack_i(fetch_ack_i), .fetch_own_i(fetch_own_i),
    .desc_done_i(desc_done_i), .state_o(tx_st), .base_addr_o(tx_base),
    .cur_addr_o(tx_cur), .int_status_o(tx_sts), .frame_wait_o(tx_wait));

  dma_poll_ctrl #(.IS_RX(1'b1)) u_dma_poll_ctrl_rx (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .demand_wr_i(demand_wr_i), .base_wr_i(base_wr_i), .base_wdata_i(base_wdata_i),
    .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i), .fetch_req_o(rx_req),
    .fetch_addr_o(rx_faddr), .fetch_ack_i(fetch_ack_i), .fetch_own_i(fetch_own_i),
    .desc_done_i(desc_done_i), .state_o(rx_st), .base_addr_o(rx_base),
    .cur_addr_o(rx_cur), .int_status_o(rx_sts), .frame_wait_o(rx_wait));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_base = '0; m_cur = '0; m_bu_tx = 0; m_bu_rx = 0; m_pend = 0;
  endtask

  task automatic model_step();
    int          nst = m_st;
    logic [31:0] nbase = m_base, ncur = m_cur;
    bit          npend = m_pend, nbu_tx = m_bu_tx, nbu_rx = m_bu_rx, setb = 0;
    if (sts_wr_i && sts_wdata_i[2]) nbu_tx = 0;
    if (sts_wr_i && sts_wdata_i[7]) nbu_rx = 0;
    case (m_st)
      0: begin
        npend = 0;
        if (base_wr_i) nbase = {base_wdata_i[31:2], 2'b00};
        if (start_i) begin nst = 1; ncur = m_base; end
      end
      1: begin
        if (stop_i) npend = 1;
        if (fetch_ack_i) begin
          if (fetch_own_i) nst = 3;
          else begin
            setb = 1;
            if (m_pend || stop_i) begin nst = 0; npend = 0; end
            else nst = 2;
          end
        end
      end
      2: begin
        if (stop_i) begin nst = 0; npend = 0; end
        else if (demand_wr_i) nst = 1;
      end
      default: begin
        if (stop_i) npend = 1;
        if (desc_done_i) begin
          if (m_pend || stop_i) begin nst = 0; npend = 0; end
          else begin ncur = m_cur + STRIDE; nst = 1; end
        end
      end
    endcase
    if (setb) begin nbu_tx = 1; nbu_rx = 1; end
    m_st = nst; m_base = nbase; m_cur = ncur; m_pend = npend;
    m_bu_tx = nbu_tx; m_bu_rx = nbu_rx;
  endtask

  task automatic compare_all();
    chk("model state tx", 32'(tx_st), 32'(m_st));
    chk("model state rx", 32'(rx_st), 32'(m_st));
    chk("model base", tx_base, m_base);
    chk("model cur", rx_cur, m_cur);
    chk("model req R4", 32'(tx_req), 32'(m_st == 1));
    if (m_st == 1) chk("model fetch addr R4", rx_faddr, m_cur);
    chk("model status tx R6", tx_sts, m_bu_tx ? 32'h4 : 32'h0);
    chk("model status rx R6", rx_sts, m_bu_rx ? 32'h80 : 32'h0);
    chk("model wait R11", {30'd0, rx_wait, tx_wait}, {30'd0, m_st == 3, 1'b0});
  endtask

  task automatic clear_inputs();
    start_i = 0; stop_i = 0; demand_wr_i = 0; base_wr_i = 0; sts_wr_i = 0;
    fetch_ack_i = 0; fetch_own_i = 0; desc_done_i = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    clear_inputs();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 state", 32'(tx_st), 32'd0);
    chk("R1 base", tx_base, 32'd0);
    chk("R1 cur", tx_cur, 32'd0);
    chk("R1 status", tx_sts | rx_sts, 32'd0);
    chk("R1 req", 32'(tx_req | rx_req), 32'd0);

    base_wr_i = 1; base_wdata_i = 32'h1234_567F; step();
    chk("R2 aligned base", tx_base, 32'h1234_567C);

    start_i = 1; step();
    chk("R3 fetching", 32'(tx_st), 32'd1);
    chk("R3 fetch addr", tx_faddr, 32'h1234_567C);

    step();
    chk("R4 req held", 32'(tx_req), 32'd1);
    chk("R4 addr held", tx_faddr, 32'h1234_567C);

    // unavailable descriptor collides with a status clear
    fetch_ack_i = 1; fetch_own_i = 0; sts_wr_i = 1; sts_wdata_i = '1; step();
    chk("R6 suspended", 32'(tx_st), 32'd2);
    chk("R10 set beats clear tx", tx_sts, 32'h4);
    chk("R6 rx bit 7", rx_sts, 32'h80);

    base_wr_i = 1; base_wdata_i = 32'hAAAA_0000; step();
    chk("R2 base locked", tx_base, 32'h1234_567C);

    sts_wr_i = 1; sts_wdata_i = 32'h0000_0000; step();
    chk("R10 no-bit write", tx_sts, 32'h4);

    sts_wr_i = 1; sts_wdata_i = 32'h0000_0004; step();
    chk("R10 tx cleared", tx_sts, 32'h0);
    chk("R10 rx kept", rx_sts, 32'h80);
    sts_wr_i = 1; sts_wdata_i = 32'h0000_0080; step();
    chk("R10 rx cleared", rx_sts, 32'h0);

    demand_wr_i = 1; step();
    chk("R7 demand in suspend", 32'(tx_st), 32'd1);
    chk("R7 same address", tx_faddr, 32'h1234_567C);

    fetch_ack_i = 1; fetch_own_i = 1; step();
    chk("R5 running", 32'(tx_st), 32'd3);
    chk("R11 rx waiting", 32'(rx_wait), 32'd1);
    chk("R11 tx not waiting", 32'(tx_wait), 32'd0);

    demand_wr_i = 1; start_i = 1; step();
    chk("R7 demand in run ignored", 32'(tx_st), 32'd3);
    chk("R3 start in run ignored", tx_cur, 32'h1234_567C);

    desc_done_i = 1; step();
    chk("R8 refetch", 32'(tx_st), 32'd1);
    chk("R8 stride", tx_faddr, 32'h1234_568C);

    fetch_ack_i = 1; fetch_own_i = 1; step();
    stop_i = 1; step();
    chk("R9 stop deferred", 32'(tx_st), 32'd3);
    desc_done_i = 1; step();
    chk("R9 stopped at done", 32'(tx_st), 32'd0);

    demand_wr_i = 1; step();
    chk("R7 demand in stop ignored", 32'(tx_st), 32'd0);

    // pseudo-random stretch against the model
    for (int i = 0; i < 6000; i++) begin
      start_i      = ($urandom % 12) == 0;
      stop_i       = ($urandom % 20) == 0;
      demand_wr_i  = ($urandom % 5) == 0;
      base_wr_i    = ($urandom % 5) == 0;
      base_wdata_i = $urandom;
      sts_wr_i     = ($urandom % 3) == 0;
      sts_wdata_i  = {24'd0, ($urandom % 2) == 0, 4'd0, ($urandom % 2) == 0, 2'd0};
      fetch_ack_i  = (m_st == 1) && (($urandom % 3) == 0);
      fetch_own_i  = ($urandom % 2) == 0;
      desc_done_i  = ($urandom % 4) == 0;
      step();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule